// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block gathers the interrupt causes of a UART core and turns them into one active-high interrupt request plus an identification byte. The causes are receive errors (overrun, parity, framing, break), a received character ready, the transmit holding register emptying, and a change on any modem handshake line. Each cause arrives as a single-cycle pulse from logic outside this block. The serial engines, baud timing and line synchronizers are not part of it.

Every cause group has a pending flag and an enable bit. The highest-priority enabled pending group drives the identification byte. The flags are cleared as a side effect of ordinary register accesses, which come in as decoded one-cycle read and write strobes with a 3-bit address. Because of this, a driver can service interrupts by reading the identification byte and then performing the access that clears the reported cause.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq` is 0, `iid` is 8'h01, and all enable bits are 0.
- R2: A write strobe at address 1 loads `wdata[3:0]` into the enable bits: bit 0 is data ready, bit 1 is transmit empty, bit 2 is line status and bit 3 is modem status.
- R2 (continued): A group's flag is set only while its enable bit is 1. A group whose enable bit is 0 never raises `irq`. Setting the bit again makes a flag that is still held visible once more.
- R3: `irq` is 1 exactly when some enabled flag is pending. `iid[0]` is the inverse of `irq`. `iid[2:1]` holds 11 for line status, 10 for data ready, 01 for transmit empty and 00 for modem status (or when nothing is pending). `iid[7:3]` is 0.
- R4: Priority from highest to lowest is: line status, data ready, transmit empty, modem status.
- R5: A pulse on any bit of `line_err` sets the line-status flag. A read at address 5 clears it.
- R6: A `rx_ready` pulse sets the data-ready flag. A read at address 0 clears it.
- R7: A `tx_empty` pulse sets the transmit-empty flag. A write at address 0 clears it.
- R8: A read at address 2 clears the transmit-empty flag only if that same read returned code 01 with `iid[0]`=0. If a higher level was being reported, the flag stays set.
- R9: A pulse on any bit of `modem_chg` sets the modem-status flag. A read at address 6 clears it.
- R10: When the reported level is cleared, `irq` and `iid` move to the next pending level in the first cycle after the clearing edge.
- R11: If a set pulse and a clearing access for the same group arrive in the same cycle, the flag ends up set.
- R12: Reads and writes at addresses 3, 4 and 7 change no flag and no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle decoded register read strobe |
| wr_stb | input | 1 | One-cycle decoded register write strobe |
| addr | input | 3 | Register address of the access |
| wdata | input | 4 | Enable bits written at address 1 |
| line_err | input | 4 | Receive error pulses: overrun, parity, framing, break |
| rx_ready | input | 1 | Received character ready pulse |
| tx_empty | input | 1 | Transmit holding register empty pulse |
| modem_chg | input | 4 | Change pulses for the four modem handshake lines |
| irq | output | 1 | Interrupt request, active high |
| iid | output | 8 | Identification byte |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that the cause inputs are clean one-cycle pulses synchronous to `clk`. As a consequence, a clearing read is taken to be the only thing acting on a group in that cycle, unless a set pulse for that group arrives alongside it. The bench drives every strobe and pulse for exactly one cycle, starting on a falling edge, and never overlaps a read with a write. The only overlaps it creates between a set pulse and a clear are the deliberate ones that exercise R11.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 4;
    localparam int ADDR_W  = 3;

    // source index doubles as enable bit position
    localparam int SRC_RDA  = 0;
    localparam int SRC_THRE = 1;
    localparam int SRC_LS   = 2;
    localparam int SRC_MS   = 3;

    localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_EN    = 3'd1;
    localparam logic [ADDR_W-1:0] A_IDENT = 3'd2;
    localparam logic [ADDR_W-1:0] A_LSTAT = 3'd5;
    localparam logic [ADDR_W-1:0] A_MSTAT = 3'd6;

    typedef enum logic [1:0] {
        LVL_MS   = 2'b00,
        LVL_THRE = 2'b01,
        LVL_RDA  = 2'b10,
        LVL_LS   = 2'b11
    } lvl_e;

    typedef struct packed {
        logic hit;
        lvl_e lvl;
    } enc_t;

    typedef struct packed {
        logic rd_data;
        logic wr_data;
        logic rd_ident;
        logic rd_lstat;
        logic rd_mstat;
    } acc_t;

    function automatic logic [7:0] make_iid(enc_t e);
        return {5'b0, e.lvl, ~e.hit};
    endfunction

    function automatic int src_of(lvl_e l);
        case (l)
            LVL_LS:   return SRC_LS;
            LVL_RDA:  return SRC_RDA;
            LVL_THRE: return SRC_THRE;
            default:  return SRC_MS;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_stb,
    input  logic                wr_stb,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_SRC-1:0]  wdata,
    output logic [NUM_SRC-1:0]  en,
    output acc_t                acc
);

    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (wr_stb && addr == A_EN)
            en <= wdata;
    end

    always_comb begin
        acc.rd_data  = rd_stb && (addr == A_DATA);
        acc.wr_data  = wr_stb && (addr == A_DATA);
        acc.rd_ident = rd_stb && (addr == A_IDENT);
        acc.rd_lstat = rd_stb && (addr == A_LSTAT);
        acc.rd_mstat = rd_stb && (addr == A_MSTAT);
    end

endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  set,
    input  logic [NUM_SRC-1:0]  clr,
    output logic [NUM_SRC-1:0]  flag
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flag[i] <= 1'b0;
            else if (set[i])
                flag[i] <= 1'b1;
            else if (clr[i])
                flag[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] eff,
    output enc_t               enc
);

    always_comb begin
        enc.hit = |eff;
        if (eff[SRC_LS])
            enc.lvl = LVL_LS;
        else if (eff[SRC_RDA])
            enc.lvl = LVL_RDA;
        else if (eff[SRC_THRE])
            enc.lvl = LVL_THRE;
        else
            enc.lvl = LVL_MS;
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int LINE_ERR_W = 4,
    parameter int MODEM_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_stb,
    input  logic                  wr_stb,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_SRC-1:0]    wdata,
    input  logic [LINE_ERR_W-1:0] line_err,
    input  logic                  rx_ready,
    input  logic                  tx_empty,
    input  logic [MODEM_W-1:0]    modem_chg,
    output logic                  irq,
    output logic [7:0]            iid
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] ev;
    logic [NUM_SRC-1:0] set;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] eff;
    acc_t               acc;
    enc_t               enc;

    uart_irq_regif u_regif (
        .clk    (clk),
        .rst    (rst),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .addr   (addr),
        .wdata  (wdata),
        .en     (en_q),
        .acc    (acc)
    );

    always_comb begin
        ev[SRC_RDA]  = rx_ready;
        ev[SRC_THRE] = tx_empty;
        ev[SRC_LS]   = |line_err;
        ev[SRC_MS]   = |modem_chg;
        set          = ev & en_q;

        clr[SRC_RDA]  = acc.rd_data;
        clr[SRC_LS]   = acc.rd_lstat;
        clr[SRC_MS]   = acc.rd_mstat;
        clr[SRC_THRE] = acc.wr_data ||
                        (acc.rd_ident && enc.hit && enc.lvl == LVL_THRE);
    end

    uart_irq_pending u_pending (
        .clk  (clk),
        .rst  (rst),
        .set  (set),
        .clr  (clr),
        .flag (flag_q)
    );

    assign eff = flag_q & en_q;

    uart_irq_prio u_prio (
        .eff (eff),
        .enc (enc)
    );

    assign irq = enc.hit;
    assign iid = make_iid(enc);

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk
    import uart_irq_pkg::*;
#(
    parameter int LINE_ERR_W = 4,
    parameter int MODEM_W    = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  rd_stb,
    input logic                  wr_stb,
    input logic [ADDR_W-1:0]     addr,
    input logic [LINE_ERR_W-1:0] line_err,
    input logic                  rx_ready,
    input logic                  tx_empty,
    input logic [MODEM_W-1:0]    modem_chg,
    input logic [NUM_SRC-1:0]    en,
    input logic                  irq,
    input logic [7:0]            iid
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R3
    iid_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (irq != iid[0]) && (iid[7:3] == 5'b0));

    // R2
    mask_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> en[src_of(lvl_e'(iid[2:1]))]);

    // R5
    ls_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rd_stb && addr == A_LSTAT && line_err == '0))
        |-> !(irq && iid[2:1] == 2'b11));

    // R7
    thre_wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wr_stb && addr == A_DATA && !tx_empty))
        |-> !(irq && iid[2:1] == 2'b01));

    // R9
    ms_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rd_stb && addr == A_MSTAT && modem_chg == '0))
        |-> !(irq && iid[2:1] == 2'b00));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rx_ready && en[SRC_RDA] && !(wr_stb && addr == A_EN)))
        |-> irq);

endmodule

bind uart_irq_ctrl uart_irq_chk #(
    .LINE_ERR_W (LINE_ERR_W),
    .MODEM_W    (MODEM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .addr      (addr),
    .line_err  (line_err),
    .rx_ready  (rx_ready),
    .tx_empty  (tx_empty),
    .modem_chg (modem_chg),
    .en        (en_q),
    .irq       (irq),
    .iid       (iid)
);

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [2:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] line_err = '0;
    logic       rx_ready = 1'b0;
    logic       tx_empty = 1'b0;
    logic [3:0] modem_chg = '0;
    logic       irq;
    logic [7:0] iid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ctrl dut (
        .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .addr(addr), .wdata(wdata), .line_err(line_err),
        .rx_ready(rx_ready), .tx_empty(tx_empty), .modem_chg(modem_chg),
        .irq(irq), .iid(iid)
    );

    task automatic chk(string req, logic [7:0] exp);
        checks++;
        if (iid !== exp || irq !== ~exp[0]) begin
            errors++;
            $display("FAIL %s: iid=%h irq=%b expected iid=%h irq=%b",
                     req, iid, irq, exp, ~exp[0]);
        end
    endtask

    task automatic idle;
        rd_stb = 0; wr_stb = 0; line_err = '0; rx_ready = 0;
        tx_empty = 0; modem_chg = '0;
    endtask

    task automatic rd(logic [2:0] a);
        @(negedge clk); idle(); rd_stb = 1; addr = a;
        @(negedge clk); idle();
    endtask

    task automatic wr(logic [2:0] a, logic [3:0] d);
        @(negedge clk); idle(); wr_stb = 1; addr = a; wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic pulse(logic [3:0] le, logic rx, logic tx, logic [3:0] mc);
        @(negedge clk); idle();
        line_err = le; rx_ready = rx; tx_empty = tx; modem_chg = mc;
        @(negedge clk); idle();
    endtask

    task automatic t_reset;
        @(negedge clk); chk("R1 reset", 8'h01);
        pulse(4'hF, 1, 1, 4'hF);
        chk("R1 all enables zero after reset", 8'h01);
    endtask

    task automatic t_mask;
        wr(3'd1, 4'b0001);
        chk("R2 flag not set while disabled", 8'h01);
        pulse(0, 1, 0, 0);
        chk("R6 data ready raised", 8'h04);
        wr(3'd1, 4'b0000);
        chk("R2 disabled source hidden", 8'h01);
        wr(3'd1, 4'b0001);
        chk("R2 held flag visible again", 8'h04);
        rd(3'd0);
        chk("R6 cleared by data read", 8'h01);
    endtask

    task automatic t_line;
        wr(3'd1, 4'hF);
        for (int b = 0; b < 4; b++) begin
            pulse(4'(1 << b), 0, 0, 0);
            chk("R5 line error sets", 8'h06);
            rd(3'd3); wr(3'd3, 4'h0); rd(3'd4); wr(3'd4, 4'h0); rd(3'd7);
            chk("R12 other addresses no effect", 8'h06);
            rd(3'd5);
            chk("R5 cleared by status read", 8'h01);
        end
    endtask

    task automatic t_thre;
        pulse(0, 0, 1, 0);
        chk("R7 transmit empty raised", 8'h02);
        wr(3'd0, 4'h0);
        chk("R7 cleared by data write", 8'h01);
        pulse(0, 0, 1, 0);
        @(negedge clk); idle(); rd_stb = 1; addr = 3'd2;
        #1 chk("R8 ident read returns transmit empty", 8'h02);
        @(negedge clk); idle();
        chk("R8 cleared by ident read", 8'h01);
    endtask

    task automatic t_modem;
        for (int b = 0; b < 4; b++) begin
            pulse(0, 0, 0, 4'(1 << b));
            chk("R9 modem change sets", 8'h00);
            rd(3'd6);
            chk("R9 cleared by modem read", 8'h01);
        end
    endtask

    task automatic t_priority;
        pulse(4'h2, 1, 1, 4'h1);
        chk("R4 line status highest", 8'h06);
        rd(3'd2);
        chk("R8 ident read with line status reported", 8'h06);
        rd(3'd5);
        chk("R10 falls to data ready", 8'h04);
        rd(3'd2);
        rd(3'd0);
        chk("R8 transmit empty survives non-matching ident read", 8'h02);
        rd(3'd2);
        chk("R10 falls to modem status", 8'h00);
        rd(3'd6);
        chk("R10 nothing pending", 8'h01);
    endtask

    task automatic t_set_wins;
        @(negedge clk); idle(); rx_ready = 1; rd_stb = 1; addr = 3'd0;
        @(negedge clk); idle();
        chk("R11 set beats clear", 8'h04);
        rd(3'd0);
        chk("R11 later clear works", 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_mask();
        t_line();
        t_thre();
        t_modem();
        t_priority();
        t_set_wins();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule